// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block sits behind a serial link front end that has already turned the line traffic into bytes. It reads one-byte commands and their operands from a valid/ready byte stream and runs them against a byte-wide flash array through a simple synchronous memory port. The port has an address, write data, a write enable, one strobe that erases the whole array and one that erases a single block. Read data returns on the clock after the address is presented. When a command ends, the block returns one status byte on a second valid/ready stream.

Erase, blank check and verify each work on the whole array or on one block named by a one-byte operand. A write gives a start address and a byte count, and the data bytes follow in the stream. A location is programmed only if it still holds the erased value. A blank check stops at the first location that is not erased. After a verify or write has failed, the rest of that command's data is read from the stream and dropped, so the next command byte is still found in the right place.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `st_valid` is 0, and `mem_we`, `mem_erase_all` and `mem_erase_blk` are all 0.
- R2: Opcodes are 0x10 erase all, 0x11 erase block, 0x20 blank-check all, 0x21 blank-check block, 0x40 write, 0x50 verify all and 0x51 verify block. Any other opcode byte returns status 0x02 and causes no memory access. Status codes are 0x00 pass, 0x01 fail and 0x02 error.
- R3: Erase all (0x10) raises `mem_erase_all` for one cycle, so every location reads 0xFF, and returns 0x00.
- R4: Erase block (0x11, then one block-number byte) raises `mem_erase_blk` for one cycle with `mem_addr` equal to block×256. Only that block of 256 bytes is erased, and the status is 0x00. A block number of 16 or more on any block command returns 0x02 and touches nothing.
- R5: A blank check returns 0x00 when every location in its range (the whole 4096-byte array, or one block) reads 0xFF. Otherwise it returns 0x01, and it ends within a few cycles of the first location that is not erased.
- R6: Write (0x40) takes a 2-byte address and then a 2-byte count, each sent low byte first, followed by that many data bytes. The bytes are stored at consecutive addresses, and addresses wrap modulo 4096. A count of 0 returns 0x00 at once.
- R7: A write data byte whose target location is not 0xFF is not stored. No later byte of the same write is stored, every remaining data byte is still taken from the stream, and the status is 0x01.
- R8: Verify compares the stream with the whole array (4096 bytes) or with one block (256 bytes) in address order. It returns 0x00 if every byte matches. After the first mismatch it stops comparing, takes and drops the remaining bytes, and returns 0x01.
- R9: `in_ready` is 0 during an erase or blank-check sweep and while a status byte is pending. No command byte is taken until the status handshake has completed.
- R10: While `st_valid` is 1 and `st_ready` is 0, `st_valid` stays 1 and `st_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command/data byte is valid |
| in_data | input | 8 | Command, operand or data byte |
| in_ready | output | 1 | Sequencer takes the byte on this edge |
| st_valid | output | 1 | Status byte is valid |
| st_data | output | 8 | Status code |
| st_ready | input | 1 | Consumer takes the status byte |
| mem_addr | output | 12 | Array byte address |
| mem_wdata | output | 8 | Byte to program |
| mem_we | output | 1 | Program the byte at `mem_addr` |
| mem_erase_all | output | 1 | Erase the whole array |
| mem_erase_blk | output | 1 | Erase the block selected by `mem_addr[11:8]` |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |

## Verification
The bench starts from an array that holds a non-erased pattern. The first blank check therefore shows the early stop on a fail, and a check after the erase has to sweep all 4096 bytes. Writes are placed so that they cross the block 0/1 boundary, wrap from 0xFFF to 0x000, hit a location that is already programmed with erased bytes after it, or carry a zero count. A read-back by verify then shows whether each byte landed, was refused, or stayed untouched. Verify is run with matching data and with one corrupted byte. A command sent right after each case shows that the stream is still framed correctly. Block operands of 16 are tried on erase and blank check, and an unknown opcode is held unacknowledged to show that the status and ready behave correctly.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam logic [7:0] OPC_ERASE_ALL  = 8'h10;
    localparam logic [7:0] OPC_ERASE_BLK  = 8'h11;
    localparam logic [7:0] OPC_BLANK_ALL  = 8'h20;
    localparam logic [7:0] OPC_BLANK_BLK  = 8'h21;
    localparam logic [7:0] OPC_WRITE      = 8'h40;
    localparam logic [7:0] OPC_VERIFY_ALL = 8'h50;
    localparam logic [7:0] OPC_VERIFY_BLK = 8'h51;

    localparam logic [7:0] ST_PASS = 8'h00;
    localparam logic [7:0] ST_FAIL = 8'h01;
    localparam logic [7:0] ST_ERR  = 8'h02;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        OPK_ERASE,
        OPK_BLANK,
        OPK_WRITE,
        OPK_VERIFY,
        OPK_BAD
    } opk_e;

    typedef enum logic [3:0] {
        S_OP,
        S_ARG,
        S_ERASE,
        S_BRD,
        S_BCMP,
        S_WIN,
        S_WCMP,
        S_VIN,
        S_VCMP,
        S_DRAIN,
        S_STAT
    } fsm_e;

endpackage

// File: rtl/fseq_opdec.sv
module fseq_opdec
    import fseq_pkg::*;
(
    input  logic [7:0] opc_i,
    output opk_e       kind_o,
    output logic       whole_o,
    output logic [2:0] nargs_o
);

    always_comb begin
        kind_o  = OPK_BAD;
        whole_o = 1'b0;
        nargs_o = 3'd0;
        case (opc_i)
            OPC_ERASE_ALL: begin
                kind_o  = OPK_ERASE;
                whole_o = 1'b1;
            end
            OPC_ERASE_BLK: begin
                kind_o  = OPK_ERASE;
                nargs_o = 3'd1;
            end
            OPC_BLANK_ALL: begin
                kind_o  = OPK_BLANK;
                whole_o = 1'b1;
            end
            OPC_BLANK_BLK: begin
                kind_o  = OPK_BLANK;
                nargs_o = 3'd1;
            end
            OPC_WRITE: begin
                kind_o  = OPK_WRITE;
                nargs_o = 3'd4;
            end
            OPC_VERIFY_ALL: begin
                kind_o  = OPK_VERIFY;
                whole_o = 1'b1;
            end
            OPC_VERIFY_BLK: begin
                kind_o  = OPK_VERIFY;
                nargs_o = 3'd1;
            end
            default: begin
                kind_o = OPK_BAD;
            end
        endcase
    end

endmodule

// File: rtl/fseq_span_ctr.sv
module fseq_span_ctr #(
    parameter int AW = 12,
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] remain_o,
    output logic          last_o
);

    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
    } span_s;

    span_s span_d, span_q;

    always_comb begin
        span_d = span_q;
        if (load_i) begin
            span_d.addr = addr_i;
            span_d.rem  = cnt_i;
        end else if (step_i) begin
            span_d.addr = span_q.addr + ONE_A;
            span_d.rem  = span_q.rem - ONE_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q <= '0;
        end else begin
            span_q <= span_d;
        end
    end

    assign addr_o   = span_q.addr;
    assign remain_o = span_q.rem;
    assign last_o   = (span_q.rem == ONE_C);

    // R6: the sequencer never steps past the end of a span
    a_r6_step_live: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i |-> remain_o != '0);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              st_valid,
    output logic [7:0]        st_data,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_erase_all,
    output logic              mem_erase_blk,
    input  logic [7:0]        mem_rdata
);

    localparam int BLKN_W  = ADDR_W - BLK_W;
    localparam int NUM_BLK = 1 << BLKN_W;
    localparam int CNT_W   = ((ADDR_W > 16) ? ADDR_W : 16) + 1;
    localparam logic [CNT_W-1:0] LEN_ALL = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LEN_BLK = CNT_W'(1 << BLK_W);

    typedef struct packed {
        fsm_e        st;
        opk_e        kind;
        logic        whole;
        logic [2:0]  need;
        logic [2:0]  got;
        logic [31:0] args;
        logic [7:0]  hold;
        logic [7:0]  status;
        logic        bad;
    } seq_s;

    seq_s seq_d, seq_q;

    opk_e        dec_kind;
    logic        dec_whole;
    logic [2:0]  dec_nargs;

    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_ld_addr;
    logic [CNT_W-1:0]  ctr_ld_cnt;
    logic              ctr_step;
    logic [ADDR_W-1:0] ctr_addr;
    logic [CNT_W-1:0]  ctr_rem;
    logic              ctr_last;

    logic accept;
    logic rd_erased;

    fseq_opdec u_opdec (
        .opc_i   (in_data),
        .kind_o  (dec_kind),
        .whole_o (dec_whole),
        .nargs_o (dec_nargs)
    );

    fseq_span_ctr #(
        .AW (ADDR_W),
        .CW (CNT_W)
    ) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ctr_load),
        .addr_i   (ctr_ld_addr),
        .cnt_i    (ctr_ld_cnt),
        .step_i   (ctr_step),
        .addr_o   (ctr_addr),
        .remain_o (ctr_rem),
        .last_o   (ctr_last)
    );

    // Byte stream and status handshakes depend on state only
    always_comb begin
        case (seq_q.st)
            S_OP, S_ARG, S_WIN, S_VIN, S_DRAIN: in_ready = 1'b1;
            default:                            in_ready = 1'b0;
        endcase
    end

    assign accept    = in_valid && in_ready;
    assign st_valid  = (seq_q.st == S_STAT);
    assign st_data   = seq_q.status;
    assign rd_erased = (mem_rdata == ERASED_BYTE);

    // Memory port
    always_comb begin
        if (seq_q.st == S_ERASE) begin
            mem_addr = {seq_q.args[BLKN_W-1:0], BLK_W'(0)};
        end else begin
            mem_addr = ctr_addr;
        end
    end

    assign mem_wdata     = seq_q.hold;
    assign mem_we        = (seq_q.st == S_WCMP) && rd_erased && !seq_q.bad;
    assign mem_erase_all = (seq_q.st == S_ERASE) && seq_q.whole;
    assign mem_erase_blk = (seq_q.st == S_ERASE) && !seq_q.whole;

    // Next-state logic
    always_comb begin
        logic [31:0] a;
        logic        go;
        logic        blk_bad;
        logic        miss;

        seq_d       = seq_q;
        ctr_load    = 1'b0;
        ctr_ld_addr = '0;
        ctr_ld_cnt  = '0;
        ctr_step    = 1'b0;
        a           = seq_q.args;
        go          = 1'b0;
        blk_bad     = 1'b0;
        miss        = 1'b0;

        case (seq_q.st)
            S_OP: begin
                if (accept) begin
                    seq_d.kind  = dec_kind;
                    seq_d.whole = dec_whole;
                    seq_d.need  = dec_nargs;
                    seq_d.got   = 3'd0;
                    seq_d.bad   = 1'b0;
                    a           = '0;
                    seq_d.args  = '0;
                    if (dec_kind == OPK_BAD) begin
                        seq_d.status = ST_ERR;
                        seq_d.st     = S_STAT;
                    end else if (dec_nargs == 3'd0) begin
                        go = 1'b1;
                    end else begin
                        seq_d.st = S_ARG;
                    end
                end
            end
            S_ARG: begin
                if (accept) begin
                    a[8*seq_q.got +: 8] = in_data;
                    seq_d.args = a;
                    seq_d.got  = seq_q.got + 3'd1;
                    if ((seq_q.got + 3'd1) == seq_q.need) begin
                        go = 1'b1;
                    end
                end
            end
            S_ERASE: begin
                seq_d.status = ST_PASS;
                seq_d.st     = S_STAT;
            end
            S_BRD: begin
                seq_d.st = S_BCMP;
            end
            S_BCMP: begin
                if (!rd_erased) begin
                    seq_d.status = ST_FAIL;
                    seq_d.st     = S_STAT;
                end else if (ctr_last) begin
                    seq_d.status = ST_PASS;
                    seq_d.st     = S_STAT;
                end else begin
                    ctr_step = 1'b1;
                    seq_d.st = S_BRD;
                end
            end
            S_WIN: begin
                if (accept) begin
                    seq_d.hold = in_data;
                    seq_d.st   = S_WCMP;
                end
            end
            S_WCMP: begin
                ctr_step  = 1'b1;
                seq_d.bad = seq_q.bad || !rd_erased;
                if (ctr_last) begin
                    seq_d.status = seq_d.bad ? ST_FAIL : ST_PASS;
                    seq_d.st     = S_STAT;
                end else if (seq_d.bad) begin
                    seq_d.st = S_DRAIN;
                end else begin
                    seq_d.st = S_WIN;
                end
            end
            S_VIN: begin
                if (accept) begin
                    seq_d.hold = in_data;
                    seq_d.st   = S_VCMP;
                end
            end
            S_VCMP: begin
                ctr_step = 1'b1;
                miss     = (mem_rdata != seq_q.hold);
                if (ctr_last) begin
                    seq_d.status = miss ? ST_FAIL : ST_PASS;
                    seq_d.st     = S_STAT;
                end else if (miss) begin
                    seq_d.bad = 1'b1;
                    seq_d.st  = S_DRAIN;
                end else begin
                    seq_d.st = S_VIN;
                end
            end
            S_DRAIN: begin
                if (accept) begin
                    ctr_step = 1'b1;
                    if (ctr_last) begin
                        seq_d.status = ST_FAIL;
                        seq_d.st     = S_STAT;
                    end
                end
            end
            S_STAT: begin
                if (st_ready) begin
                    seq_d.bad = 1'b0;
                    seq_d.st  = S_OP;
                end
            end
            default: begin
                seq_d.st = S_OP;
            end
        endcase

        // Operands complete: launch the command
        if (go) begin
            blk_bad = !seq_d.whole && (32'(a[7:0]) >= 32'(NUM_BLK));
            case (seq_d.kind)
                OPK_ERASE: begin
                    if (blk_bad) begin
                        seq_d.status = ST_ERR;
                        seq_d.st     = S_STAT;
                    end else begin
                        seq_d.st = S_ERASE;
                    end
                end
                OPK_BLANK, OPK_VERIFY: begin
                    if (blk_bad) begin
                        seq_d.status = ST_ERR;
                        seq_d.st     = S_STAT;
                    end else begin
                        ctr_load    = 1'b1;
                        ctr_ld_addr = seq_d.whole ? '0 : {a[BLKN_W-1:0], BLK_W'(0)};
                        ctr_ld_cnt  = seq_d.whole ? LEN_ALL : LEN_BLK;
                        seq_d.st    = (seq_d.kind == OPK_BLANK) ? S_BRD : S_VIN;
                    end
                end
                OPK_WRITE: begin
                    if (a[31:16] == 16'h0000) begin
                        seq_d.status = ST_PASS;
                        seq_d.st     = S_STAT;
                    end else begin
                        ctr_load    = 1'b1;
                        ctr_ld_addr = a[ADDR_W-1:0];
                        ctr_ld_cnt  = CNT_W'(a[31:16]);
                        seq_d.st    = S_WIN;
                    end
                end
                default: begin
                    seq_d.status = ST_ERR;
                    seq_d.st     = S_STAT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= S_OP;
            seq_q.kind   <= OPK_BAD;
            seq_q.status <= ST_PASS;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R10: pending status is held until taken
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data));

    // R9: status only retires through the handshake
    a_r9_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_valid) |-> $past(st_ready));

    // R9: no byte is taken while an erase is issued
    a_r9_erase_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_erase_all || mem_erase_blk) |-> !in_ready);

    // R3: at most one memory action per cycle
    a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_erase_all, mem_erase_blk}));

    // R4: block erase addresses the first byte of a block
    a_r4_blk_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase_blk |-> mem_addr[BLK_W-1:0] == '0);

    // R7: a program targets the location that was just read
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == $past(mem_addr));

endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

    localparam int AW = 12;
    localparam int SZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          st_valid;
    logic [7:0]    st_data;
    logic          st_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic          mem_erase_all;
    logic          mem_erase_blk;
    logic [7:0]    mem_rdata;

    logic [7:0] fmem    [SZ];
    logic [7:0] ref_mem [SZ];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .st_valid      (st_valid),
        .st_data       (st_data),
        .st_ready      (st_ready),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_we        (mem_we),
        .mem_erase_all (mem_erase_all),
        .mem_erase_blk (mem_erase_blk),
        .mem_rdata     (mem_rdata)
    );

    // Array model: one-cycle erase, registered read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SZ; i++) fmem[i] <= 8'(i) ^ 8'h5A;
        end else if (mem_erase_all) begin
            for (int i = 0; i < SZ; i++) fmem[i] <= 8'hFF;
        end else if (mem_erase_blk) begin
            for (int i = 0; i < 256; i++) fmem[{mem_addr[11:8], 8'(i)}] <= 8'hFF;
        end else if (mem_we) begin
            fmem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= fmem[mem_addr];
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic get_status(output logic [7:0] s);
        @(negedge clk);
        st_ready = 1'b1;
        forever begin
            if (st_valid) begin
                s = st_data;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 st_ready = 1'b0;
    endtask

    function automatic logic [7:0] blank_expect(input bit whole, input int blk);
        int lo = whole ? 0 : blk * 256;
        int n  = whole ? SZ : 256;
        for (int i = 0; i < n; i++) if (ref_mem[lo + i] != 8'hFF) return 8'h01;
        return 8'h00;
    endfunction

    task automatic erase_cmd(input bit whole, input int blk, input string req);
        logic [7:0] s;
        logic [7:0] exp = (!whole && blk >= 16) ? 8'h02 : 8'h00;
        send(whole ? 8'h10 : 8'h11);
        if (!whole) send(8'(blk));
        if (exp == 8'h00) begin
            @(negedge clk);
            chk8({req, " ready low in erase"}, {7'd0, in_ready}, 8'h00);
            chk8({req, " erase strobe"}, {6'd0, mem_erase_all, mem_erase_blk},
                 whole ? 8'h02 : 8'h01);
            if (whole) begin
                for (int i = 0; i < SZ; i++) ref_mem[i] = 8'hFF;
            end else begin
                for (int i = 0; i < 256; i++) ref_mem[blk * 256 + i] = 8'hFF;
            end
        end
        get_status(s);
        chk8({req, " erase status"}, s, exp);
    endtask

    task automatic blank_cmd(input bit whole, input int blk, input string req,
                             output int wait_cyc);
        logic [7:0] s;
        logic [7:0] exp;
        exp = (!whole && blk >= 16) ? 8'h02 : blank_expect(whole, blk);
        send(whole ? 8'h20 : 8'h21);
        if (!whole) send(8'(blk));
        wait_cyc = 0;
        @(negedge clk);
        if (exp != 8'h02) chk8("R9 ready low in blank sweep", {7'd0, in_ready}, 8'h00);
        while (!st_valid && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        get_status(s);
        chk8({req, " blank status"}, s, exp);
    endtask

    task automatic write_cmd(input int addr, input int cnt, input logic [7:0] seed,
                             input string req);
        logic [7:0] s;
        bit refused = 0;
        send(8'(addr));
        send(8'(addr >> 8));
        send(8'(cnt));
        send(8'(cnt >> 8));
        for (int i = 0; i < cnt; i++) begin
            int loc = (addr + i) % SZ;
            if (!refused && ref_mem[loc] == 8'hFF) ref_mem[loc] = seed + 8'(i);
            else refused = 1;
            send(seed + 8'(i));
        end
        get_status(s);
        chk8({req, " write status"}, s, refused ? 8'h01 : 8'h00);
    endtask

    task automatic write_op(input int addr, input int cnt, input logic [7:0] seed,
                            input string req);
        send(8'h40);
        write_cmd(addr, cnt, seed, req);
    endtask

    task automatic verify_cmd(input bit whole, input int blk, input int bad_idx,
                              input string req);
        logic [7:0] s;
        int lo = whole ? 0 : blk * 256;
        int n  = whole ? SZ : 256;
        send(whole ? 8'h50 : 8'h51);
        if (!whole) send(8'(blk));
        for (int i = 0; i < n; i++) begin
            send((i == bad_idx) ? (ref_mem[lo + i] ^ 8'h01) : ref_mem[lo + i]);
        end
        get_status(s);
        chk8({req, " verify status"}, s, (bad_idx >= 0) ? 8'h01 : 8'h00);
    endtask

    // Scenarios
    task automatic t_reset;
        chk8("R1 in_ready after reset", {7'd0, in_ready}, 8'h01);
        chk8("R1 st_valid after reset", {7'd0, st_valid}, 8'h00);
        chk8("R1 strobes after reset", {5'd0, mem_we, mem_erase_all, mem_erase_blk}, 8'h00);
    endtask

    task automatic t_bad_opcode_hold;
        logic [7:0] s;
        send(8'h77);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk8("R10 status held valid", {7'd0, st_valid}, 8'h01);
            chk8("R10 status held data", st_data, 8'h02);
            chk8("R9 not ready while status pending", {7'd0, in_ready}, 8'h00);
        end
        get_status(s);
        chk8("R2 unknown opcode", s, 8'h02);
    endtask

    task automatic t_blank_early_fail;
        int c;
        blank_cmd(1'b1, 0, "R5 unerased array", c);
        n_chk++;
        if (c > 6) begin
            n_err++;
            $display("FAIL R5 early stop: actual %0d cycles expected <= 6", c);
        end
    endtask

    task automatic t_erase_all;
        int c;
        erase_cmd(1'b1, 0, "R3");
        blank_cmd(1'b1, 0, "R3 R5 full sweep", c);
    endtask

    task automatic t_write_cross;
        write_op(12'h0FE, 4, 8'h11, "R6 cross block");
        verify_cmd(1'b0, 0, -1, "R6 R8 block 0");
        verify_cmd(1'b0, 1, -1, "R6 R8 block 1");
    endtask

    task automatic t_write_refused;
        int c;
        write_op(12'h101, 2, 8'h77, "R7 refused");
        verify_cmd(1'b0, 1, -1, "R7 memory unchanged");
        blank_cmd(1'b0, 2, "R7 framing after drain", c);
    endtask

    task automatic t_block_blank_erase;
        int c;
        blank_cmd(1'b0, 1, "R5 block fail", c);
        erase_cmd(1'b0, 1, "R4");
        blank_cmd(1'b0, 1, "R4 block erased", c);
        verify_cmd(1'b0, 0, -1, "R4 neighbour intact");
    endtask

    task automatic t_block_range;
        int c;
        erase_cmd(1'b0, 16, "R4 block 16");
        blank_cmd(1'b0, 16, "R4 block 16", c);
        verify_cmd(1'b0, 0, -1, "R4 range error left memory");
    endtask

    task automatic t_verify_mismatch;
        int c;
        verify_cmd(1'b0, 0, 5, "R8 mismatch");
        blank_cmd(1'b0, 2, "R8 framing after mismatch", c);
    endtask

    task automatic t_write_zero_and_wrap;
        int c;
        write_op(12'h200, 0, 8'h99, "R6 zero count");
        blank_cmd(1'b0, 2, "R6 zero count untouched", c);
        write_op(12'hFFF, 2, 8'hC3, "R6 wrap");
        verify_cmd(1'b1, 0, -1, "R6 R8 whole array");
    endtask

    initial begin
        for (int i = 0; i < SZ; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_opcode_hold();
        t_blank_early_fail();
        t_erase_all();
        t_write_cross();
        t_write_refused();
        t_block_blank_erase();
        t_block_range();
        t_verify_mismatch();
        t_write_zero_and_wrap();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule